// File: doc/BRIEF.md
# ECC Error-Threshold Health Monitor

After each page read, the ECC decoder reports how many bits it corrected. This block takes that count for every read and decides whether the block that was read needs maintenance. Light error loads need nothing. A moderate load asks for the data to be rewritten in place, which restores the charge levels in the cells. A heavy load, or an error the decoder could not correct, asks for the data to be moved to a healthy block. The worn source block is then recorded in a bad-block bitmap, and the allocator must never hand it out again.

The two thresholds can be changed at run time through a small configuration port. A setting is accepted only if the retire threshold is strictly above the refresh threshold; any other setting is dropped and the previous pair stays in force. A read that lands on a block already in the bitmap is reported as an anomaly and starts no further action. The decoder itself and the datapath that moves data are not part of this block. Relocated data passes through ECC correction on its way, so the destination block receives clean data.

Top module: `ecc_health_monitor`

## Requirements
- R1: After reset, all request pulses and `bad_hit` are low, `bad_map` is all zero, and the thresholds are refresh=8 and retire=20.
- R2: A read with `rd_errs` below the refresh threshold, not flagged uncorrectable, on a block that is not bad, produces no pulse.
- R3: A read with refresh threshold <= `rd_errs` <= retire threshold (both bounds inclusive), not uncorrectable, on a good block, raises `refresh_req` for one cycle. The pulse comes in the cycle after the `rd_done` edge, and `req_blk` then equals the block index.
- R4: A read with `rd_errs` strictly above the retire threshold, on a good block, raises `retire_req` for one cycle with `req_blk` set to the block. In that same cycle, bit `rd_blk` of `bad_map` reads 1.
- R5: A read with `rd_uncorr`=1 on a good block is handled as a retirement, whatever its error count.
- R6: A read of a block whose `bad_map` bit is 1 raises `bad_hit` for one cycle. It raises neither request and leaves `bad_map` unchanged.
- R7: A configuration write with retire > refresh is accepted. It governs every read whose `rd_done` edge comes after the write edge.
- R8: A configuration write with retire <= refresh is rejected, and the previous thresholds stay in force.
- R9: Each pulse lasts one cycle per read. At most one of `refresh_req`, `retire_req` and `bad_hit` is high in any cycle, and retirement wins when both thresholds are crossed.
- R10: A bit of `bad_map` never returns to 0 except through reset.
- R11: A read whose `rd_done` edge coincides with a configuration write is classified with the thresholds in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_refresh_thr | input | CNT_W | Proposed refresh threshold |
| cfg_retire_thr | input | CNT_W | Proposed retire threshold |
| rd_done | input | 1 | One-cycle strobe: a page read finished |
| rd_blk | input | BLK_W | Block index of the read |
| rd_errs | input | CNT_W | Corrected bit-error count of the read |
| rd_uncorr | input | 1 | The read held an uncorrectable error |
| refresh_req | output | 1 | Pulse: rewrite the block in place |
| retire_req | output | 1 | Pulse: relocate the block and retire it |
| bad_hit | output | 1 | Pulse: a read hit a block already marked bad |
| req_blk | output | BLK_W | Block index that goes with the pulse |
| bad_map | output | NUM_BLKS | Bad-block bitmap, one bit per block |

## Verification
A threshold write and a read classification can fall on the same clock edge. The bench provokes this by raising `cfg_we` and `rd_done` together, with an error count that the old thresholds class as retire and the new ones would ignore. The result must be a retirement. A second read right after it, with the same count, must then be ignored. A retirement and a bad-block hit on the same block also fall on consecutive edges: two back-to-back reads of one block must give a retire pulse followed at once by `bad_hit`. A behavioural model in the bench judges every cycle.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REFRESH = 2'd1,
    ACT_RETIRE  = 2'd2,
    ACT_BADHIT  = 2'd3
  } act_e;
endpackage

// File: rtl/ecc_mon_thr.sv
// Threshold register pair with an ordering guard on writes.
module ecc_mon_thr #(
  parameter int CNT_W   = 6,
  parameter int DEF_REF = 8,
  parameter int DEF_RET = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_ref,
  input  logic [CNT_W-1:0] cfg_ret,
  output logic [CNT_W-1:0] thr_ref,
  output logic [CNT_W-1:0] thr_ret
);
  logic             accept;
  logic [CNT_W-1:0] ref_d, ret_d;

  always_comb begin
    accept = cfg_we && (cfg_ret > cfg_ref);
    ref_d  = thr_ref;
    ret_d  = thr_ret;
    if (accept) begin
      ref_d = cfg_ref;
      ret_d = cfg_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_ref <= CNT_W'(DEF_REF);
      thr_ret <= CNT_W'(DEF_RET);
    end else if (accept) begin
      thr_ref <= ref_d;
      thr_ret <= ret_d;
    end
  end
endmodule

// File: rtl/ecc_mon_class.sv
// Combinational classification of one read result.
module ecc_mon_class
  import ecc_mon_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             valid,
  input  logic             blk_bad,
  input  logic             uncorr,
  input  logic [CNT_W-1:0] errs,
  input  logic [CNT_W-1:0] thr_ref,
  input  logic [CNT_W-1:0] thr_ret,
  output act_e             act
);
  always_comb begin
    act = ACT_NONE;
    if (valid) begin
      if (blk_bad)                        act = ACT_BADHIT;
      else if (uncorr || errs > thr_ret)  act = ACT_RETIRE;
      else if (errs >= thr_ref)           act = ACT_REFRESH;
    end
  end
endmodule

// File: rtl/ecc_mon_badmap.sv
// Sticky bad-block bitmap; bits clear only on reset.
module ecc_mon_badmap #(
  parameter int NUM_BLKS = 16,
  localparam int BLK_W   = $clog2(NUM_BLKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [BLK_W-1:0]    set_idx,
  output logic [NUM_BLKS-1:0] map
);
  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_idx == BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map[g] <= 1'b0;
      else if (hit) map[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_health_monitor.sv
module ecc_health_monitor
  import ecc_mon_pkg::*;
#(
  parameter int NUM_BLKS = 16,
  parameter int CNT_W    = 6,
  parameter int DEF_REF  = 8,
  parameter int DEF_RET  = 20,
  localparam int BLK_W   = $clog2(NUM_BLKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CNT_W-1:0]    cfg_refresh_thr,
  input  logic [CNT_W-1:0]    cfg_retire_thr,
  input  logic                rd_done,
  input  logic [BLK_W-1:0]    rd_blk,
  input  logic [CNT_W-1:0]    rd_errs,
  input  logic                rd_uncorr,
  output logic                refresh_req,
  output logic                retire_req,
  output logic                bad_hit,
  output logic [BLK_W-1:0]    req_blk,
  output logic [NUM_BLKS-1:0] bad_map
);
  logic [CNT_W-1:0] thr_ref, thr_ret;
  act_e             act;
  logic             mark;
  logic             ref_d, ret_d, hit_d;
  logic [BLK_W-1:0] blk_d;

  ecc_mon_thr #(.CNT_W(CNT_W), .DEF_REF(DEF_REF), .DEF_RET(DEF_RET)) thr_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_ref(cfg_refresh_thr), .cfg_ret(cfg_retire_thr),
    .thr_ref(thr_ref), .thr_ret(thr_ret)
  );

  ecc_mon_class #(.CNT_W(CNT_W)) class_i (
    .valid(rd_done), .blk_bad(bad_map[rd_blk]), .uncorr(rd_uncorr),
    .errs(rd_errs), .thr_ref(thr_ref), .thr_ret(thr_ret), .act(act)
  );

  assign mark = (act == ACT_RETIRE);

  ecc_mon_badmap #(.NUM_BLKS(NUM_BLKS)) map_i (
    .clk(clk), .rst_n(rst_n), .set_en(mark), .set_idx(rd_blk), .map(bad_map)
  );

  always_comb begin
    ref_d = (act == ACT_REFRESH);
    ret_d = (act == ACT_RETIRE);
    hit_d = (act == ACT_BADHIT);
    blk_d = req_blk;
    if (rd_done) blk_d = rd_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_req <= 1'b0;
      retire_req  <= 1'b0;
      bad_hit     <= 1'b0;
      req_blk     <= '0;
    end else begin
      refresh_req <= ref_d;
      retire_req  <= ret_d;
      bad_hit     <= hit_d;
      req_blk     <= blk_d;
    end
  end
endmodule

// File: rtl/ecc_health_monitor_chk.sv
module ecc_health_monitor_chk #(
  parameter int NUM_BLKS = 16,
  parameter int CNT_W    = 6,
  localparam int BLK_W   = $clog2(NUM_BLKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_done,
  input logic [BLK_W-1:0]    rd_blk,
  input logic                rd_uncorr,
  input logic                refresh_req,
  input logic                retire_req,
  input logic                bad_hit,
  input logic [BLK_W-1:0]    req_blk,
  input logic [NUM_BLKS-1:0] bad_map,
  input logic [CNT_W-1:0]    thr_ref,
  input logic [CNT_W-1:0]    thr_ret
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({refresh_req, retire_req, bad_hit}) <= 1);

  assert_pulse_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req || retire_req || bad_hit) |-> $past(rd_done));

  assert_retire_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retire_req |-> bad_map[req_blk]);

  assert_sticky_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_map & $past(bad_map)) == $past(bad_map));

  assert_uncorr_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_uncorr && !bad_map[rd_blk]) |=> retire_req);

  assert_bad_read_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && bad_map[rd_blk]) |=> (bad_hit && !retire_req && !refresh_req));

  assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ret > thr_ref);
endmodule

bind ecc_health_monitor ecc_health_monitor_chk #(.NUM_BLKS(NUM_BLKS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_blk(rd_blk), .rd_uncorr(rd_uncorr),
  .refresh_req(refresh_req), .retire_req(retire_req), .bad_hit(bad_hit),
  .req_blk(req_blk), .bad_map(bad_map), .thr_ref(thr_ref), .thr_ret(thr_ret)
);

// File: tb/ecc_health_monitor_tb_top.sv
module ecc_health_monitor_tb_top;
  localparam int NB = 16;
  localparam int CW = 6;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_ref = '0, cfg_ret = '0;
  logic          rd_done = 1'b0;
  logic [BW-1:0] rd_blk = '0;
  logic [CW-1:0] rd_errs = '0;
  logic          rd_uncorr = 1'b0;
  logic          refresh_req, retire_req, bad_hit;
  logic [BW-1:0] req_blk;
  logic [NB-1:0] bad_map;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  // reference model state
  int          m_ref, m_ret;
  bit [NB-1:0] m_bad;
  bit          e_ref, e_ret, e_hit;
  int          e_blk;

  always #2 clk = ~clk;

  ecc_health_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_refresh_thr(cfg_ref), .cfg_retire_thr(cfg_ret),
    .rd_done(rd_done), .rd_blk(rd_blk), .rd_errs(rd_errs), .rd_uncorr(rd_uncorr),
    .refresh_req(refresh_req), .retire_req(retire_req), .bad_hit(bad_hit),
    .req_blk(req_blk), .bad_map(bad_map)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 8; m_ret = 20; m_bad = '0;
      e_ref = 0; e_ret = 0; e_hit = 0; e_blk = 0;
    end else begin
      e_ref = 0; e_ret = 0; e_hit = 0;
      if (rd_done) begin
        e_blk = int'(rd_blk);
        if (m_bad[rd_blk]) e_hit = 1;
        else if (rd_uncorr || int'(rd_errs) > m_ret) begin
          e_ret = 1; m_bad[rd_blk] = 1'b1;
        end else if (int'(rd_errs) >= m_ref) e_ref = 1;
      end
      if (cfg_we && int'(cfg_ret) > int'(cfg_ref)) begin
        m_ref = int'(cfg_ref); m_ret = int'(cfg_ret);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (refresh_req !== e_ref || retire_req !== e_ret || bad_hit !== e_hit ||
          bad_map !== m_bad || ((e_ref || e_ret || e_hit) && int'(req_blk) != e_blk)) begin
        errors++;
        $display("FAIL %s: got ref=%0b ret=%0b hit=%0b blk=%0d map=%h, expected ref=%0b ret=%0b hit=%0b blk=%0d map=%h",
                 cur_tag, refresh_req, retire_req, bad_hit, req_blk, bad_map,
                 e_ref, e_ret, e_hit, e_blk, m_bad);
      end
    end
  end

  task automatic rd(input string tag, input int blk, input int errs, input bit unc);
    @(negedge clk);
    cur_tag = tag;
    rd_done = 1'b1; rd_blk = BW'(blk); rd_errs = CW'(errs); rd_uncorr = unc;
    @(negedge clk);
    rd_done = 1'b0; rd_uncorr = 1'b0;
  endtask

  task automatic cfg(input string tag, input int r, input int t);
    @(negedge clk);
    cur_tag = tag;
    cfg_we = 1'b1; cfg_ref = CW'(r); cfg_ret = CW'(t);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (refresh_req || retire_req || bad_hit || bad_map != '0) begin
      errors++;
      $display("FAIL R1: got ref=%0b ret=%0b hit=%0b map=%h, expected all zero",
               refresh_req, retire_req, bad_hit, bad_map);
    end
    rd("R1", 1, 7, 0);   // default refresh threshold 8: 7 ignored
    rd("R2", 1, 3, 0);
    rd("R3", 2, 8, 0);   // lower bound inclusive
    rd("R3", 3, 20, 0);  // upper bound inclusive
    rd("R4", 4, 21, 0);
    rd("R5", 5, 0, 1);
    rd("R6", 4, 2, 0);
    rd("R6", 4, 40, 1);
    // back-to-back on one block: retire then bad hit
    @(negedge clk);
    cur_tag = "R9";
    rd_done = 1'b1; rd_blk = BW'(6); rd_errs = CW'(50);
    @(negedge clk);
    rd_errs = CW'(1);
    @(negedge clk);
    rd_done = 1'b0;
    cfg("R7", 4, 10);
    rd("R7", 7, 5, 0);
    rd("R7", 8, 11, 0);
    cfg("R8", 12, 12);
    rd("R8", 9, 5, 0);
    cfg("R8", 10, 5);
    rd("R8", 10, 10, 0);
    rd("R8", 11, 11, 0);
    // R11: config write and read on the same edge
    @(negedge clk);
    cur_tag = "R11";
    cfg_we = 1'b1; cfg_ref = CW'(30); cfg_ret = CW'(40);
    rd_done = 1'b1; rd_blk = BW'(12); rd_errs = CW'(15);
    @(negedge clk);
    cfg_we = 1'b0; rd_blk = BW'(13);
    @(negedge clk);
    rd_done = 1'b0;
    rd("R7", 14, 29, 0);
    rd("R7", 14, 35, 0);
    cur_tag = "R10";
    repeat (5) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule